// File: doc/BRIEF.md
# Board Interrupt Collector with Register Bank

This block gathers sixteen external interrupt sources into one parent interrupt line toward a host processor. It sits behind a simple synchronous register bus and also holds a small set of plain storage words for board functions: two LED data words, one LED control word, a switch word, three miscellaneous write words, one miscellaneous read word and two card-slot words. Only the enable and status words affect the interrupt path. The remaining words store what is written to them and return it when read.

Each source is synchronised and compared with its stored previous level once per clock. The status word records which enabled source moved last, as a one-hot value. The parent line copies the new level of that source. A change on a source whose enable bit is clear is only recorded in the level register. Writes to the enable and status words pass through a fixed keep pattern, so reserved bit positions, including sources 8 and 12, can never be enabled.

Top module: `irq_aggregator`

## Requirements
- R1: Each of the 16 inputs passes through SYNC_STAGES synchronising flops and is then compared with its previous level. A change becomes visible on the outputs SYNC_STAGES+1 rising clock edges after it is applied.
- R2: Byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each hold a full 32-bit word that reads back exactly as written.
- R3: The enable word (offset 0xC0) and the status word (offset 0xD0) store write data ANDed with 0x000FEEFF. Sources 8 and 12 therefore can never raise an event.
- R4: When input n changes and enable bit n is 1, the status word becomes a value with only bit n set.
- R5: In that same case the parent output takes the new level of input n.
- R6: A change on an input whose enable bit is 0 leaves both the parent output and the status word unchanged.
- R7: When several enabled inputs change in the same cycle, the one with the lowest index sets the status word and the parent level.
- R8: A read from an offset outside the map returns zero.
- R9: Read data is registered and is valid one clock after the read strobe. A write takes effect on the rising edge where write enable is high.
- R10: An active-low asynchronous reset clears every word, the level register and the read data, and drives the parent output low.
- R11: When an interrupt event and a bus write to the status word land on the same edge, the event's one-hot value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 16 | External interrupt levels |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write enable |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| parent_irq_o | output | 1 | Aggregated interrupt toward the host |

## Verification
The bench uses the default parameters: NUM_SRC=16 and SYNC_STAGES=2. With sixteen sources, the reserved keep-pattern positions 8 and 12 fall inside the source range, so the bench can show that a toggle on source 8 is never reported. Two synchroniser stages give a fixed three-edge latency, and the bench samples one edge early to confirm that nothing has moved yet. Because that latency is fixed, the bench can also place a status write on the exact edge of an event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 8;
  localparam int unsigned NREG   = 12;
  localparam int unsigned IDX_EN = 8;
  localparam int unsigned IDX_ST = 9;
  localparam logic [DW-1:0] IRQ_KEEP = 32'h000F_EEFF;

  // word index -> byte offset; indices 8/9 carry behaviour
  localparam logic [AW-1:0] REG_OFS [NREG] = '{
    8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84,
    8'h88, 8'h90, 8'hC0, 8'hD0, 8'hE0, 8'hE4
  };
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  output logic         hit_o,
  output logic [N-1:0] sel_oh_o,
  output logic         parent_o
);
  logic [N-1:0] level_q;
  logic [N-1:0] hits;
  logic         new_lvl;

  assign hits     = (lvl_i ^ level_q) & en_i;
  assign sel_oh_o = hits & (~hits + 1'b1);  // lowest index wins
  assign hit_o    = |hits;
  assign new_lvl  = |(sel_oh_o & lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      parent_o <= 1'b0;
    end else begin
      level_q <= lvl_i;
      if (hit_o) parent_o <= new_lvl;
    end
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          evt_i,
  input  logic [N-1:0]  evt_oh_i,
  output logic [N-1:0]  en_o,
  output logic [DW-1:0] en_word_o,
  output logic [DW-1:0] st_word_o
);
  logic [DW-1:0] reg_val [NREG];
  logic [DW-1:0] rd_val;
  logic [DW-1:0] evt_word;

  assign evt_word = {{(DW-N){1'b0}}, evt_oh_i};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP =
      (g == IDX_EN || g == IDX_ST) ? IRQ_KEEP : '1;
    logic [DW-1:0] q;
    logic          wsel;
    assign wsel = we_i && (addr_i == REG_OFS[g]);
    if (g == IDX_ST) begin : g_st
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (evt_i) q <= evt_word;  // hardware event beats bus write
        else if (wsel) q <= wdata_i & KEEP;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (wsel) q <= wdata_i & KEEP;
      end
    end
    assign reg_val[g] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == REG_OFS[i]) rd_val = reg_val[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (re_i)  rdata_o <= rd_val;
  end

  assign en_word_o = reg_val[IDX_EN];
  assign st_word_o = reg_val[IDX_ST];
  assign en_o      = reg_val[IDX_EN][N-1:0];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic               bus_we_i,
  input  logic               bus_re_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               parent_irq_o
);
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] en_bits;
  logic [NUM_SRC-1:0] evt_oh;
  logic               evt_hit;
  logic [DW-1:0]      en_word;
  logic [DW-1:0]      st_word;

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_src_i),
    .q_o    (src_sync)
  );

  irq_capture #(.N(NUM_SRC)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (src_sync),
    .en_i     (en_bits),
    .hit_o    (evt_hit),
    .sel_oh_o (evt_oh),
    .parent_o (parent_irq_o)
  );

  irq_reg_bank #(.N(NUM_SRC)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .re_i      (bus_re_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .evt_i     (evt_hit),
    .evt_oh_i  (evt_oh),
    .en_o      (en_bits),
    .en_word_o (en_word),
    .st_word_o (st_word)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      bus_addr_i,
  input logic               bus_we_i,
  input logic               bus_re_i,
  input logic [DW-1:0]      bus_wdata_i,
  input logic [DW-1:0]      bus_rdata_o,
  input logic               parent_irq_o,
  input logic               evt_hit,
  input logic [NUM_SRC-1:0] evt_oh,
  input logic [DW-1:0]      en_word,
  input logic [DW-1:0]      st_word
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (bus_addr_i == REG_OFS[i]) mapped = 1'b1;
  end

  // R6
  quiet_parent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_hit |=> $stable(parent_irq_o));

  // R4
  onehot_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hit |=> $countones(st_word) == 1);

  // R3
  en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_OFS[IDX_EN]) |=>
      en_word == ($past(bus_wdata_i) & IRQ_KEEP));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && !mapped) |=> bus_rdata_o == '0);

  // R11
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit && bus_we_i && bus_addr_i == REG_OFS[IDX_ST]) |=>
      st_word == {{(DW-NUM_SRC){1'b0}}, $past(evt_oh)});
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_re_i     (bus_re_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .parent_irq_o (parent_irq_o),
  .evt_hit      (evt_hit),
  .evt_oh       (evt_oh),
  .en_word      (en_word),
  .st_word      (st_word)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam logic [7:0] A_EN = 8'hC0;
  localparam logic [7:0] A_ST = 8'hD0;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h10, 32'hA5A5_0001, 32'hA5A5_0001},
    '{8'h14, 32'h5A5A_0002, 32'h5A5A_0002},
    '{8'h40, 32'h0000_00FF, 32'h0000_00FF},
    '{8'h60, 32'h1234_5678, 32'h1234_5678},
    '{8'h80, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{8'h84, 32'hCAFE_F00D, 32'hCAFE_F00D},
    '{8'h88, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    '{8'h90, 32'h8000_0001, 32'h8000_0001},
    '{8'hC0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    '{8'hD0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    '{8'hE0, 32'h1111_2222, 32'h1111_2222},
    '{8'hE4, 32'hFFFF_0000, 32'hFFFF_0000},
    '{8'h20, 32'h7777_7777, 32'h0000_0000},
    '{8'hFC, 32'h3333_3333, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        parent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .irq_src_i    (src),
    .bus_addr_i   (addr),
    .bus_we_i     (we),
    .bus_re_i     (re),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .parent_irq_o (parent)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic drive_and_wait(input logic [15:0] v);
    @(negedge clk); src = v;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    check("R10 parent after reset", {31'b0, parent}, 32'h0);
    rd(8'h80, v); check("R10 misc word after reset", v, 32'h0);
    rd(A_EN, v);  check("R10 enable after reset", v, 32'h0);

    // R2 R3 R8 R9: write all, then read all
    for (int i = 0; i < NV; i++) wr(VEC[i].addr, VEC[i].wdata);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i].addr, v);
      check($sformatf("R2/R3/R8/R9 vec %0d addr %h", i, VEC[i].addr), v, VEC[i].expv);
    end

    // R6 masked change
    wr(A_EN, 32'h3); wr(A_ST, 32'h0);
    drive_and_wait(16'h0004);
    check("R6 parent on masked change", {31'b0, parent}, 32'h0);
    rd(A_ST, v); check("R6 status on masked change", v, 32'h0);

    // R1 latency, R5 level, R4 status
    @(negedge clk); src = 16'h0005;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    check("R1 parent before latency", {31'b0, parent}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R1 R5 parent rises", {31'b0, parent}, 32'h1);
    rd(A_ST, v); check("R4 status one-hot bit0", v, 32'h1);

    // R5 falling level
    drive_and_wait(16'h0004);
    check("R5 parent falls", {31'b0, parent}, 32'h0);

    // R7 bit1 rise and bit2 fall together
    wr(A_EN, 32'h6);
    drive_and_wait(16'h0002);
    check("R7 parent from lowest", {31'b0, parent}, 32'h1);
    rd(A_ST, v); check("R7 status lowest index", v, 32'h2);

    // R3 reserved source 8
    wr(A_EN, 32'h0000_FFFF);
    rd(A_EN, v); check("R3 enable keep pattern", v, 32'h0000_EEFF);
    drive_and_wait(16'h0102);
    check("R3 source 8 parent", {31'b0, parent}, 32'h1);
    rd(A_ST, v); check("R3 source 8 status", v, 32'h2);

    // R11 event and status write on the same edge (bit1 falls)
    @(negedge clk); src = 16'h0100;
    repeat (SYNC) @(negedge clk);
    addr = A_ST; wdata = 32'hFFFF_FFFF; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R11 parent on event", {31'b0, parent}, 32'h0);
    rd(A_ST, v); check("R11 event beats write", v, 32'h2);

    // R10 reset mid-run
    drive_and_wait(16'h0101);
    check("R10 parent set before reset", {31'b0, parent}, 32'h1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R10 parent cleared", {31'b0, parent}, 32'h0);
    check("R10 rdata cleared", rdata, 32'h0);
    rst_ni = 1'b1;
    rd(8'h10, v); check("R10 LED word cleared", v, 32'h0);
    rd(A_ST, v);  check("R10 status cleared", v, 32'h0);

    finish_run();
  end
endmodule